// File: doc/BRIEF.md
# Timestamping Event Queue

This block is a single-clock queue that sits between one application processor and a security monitor. The processor pushes short event words, for example block-entry and block-exit markers. At the moment each push is accepted, the queue copies the value of its own free-running cycle counter and stores it with the word. The monitor later pops the word and its stamp together. It can then judge when each event really happened, however long the entry waited in the queue.

Each side has a request input, a status flag and a stall output. A push into a full queue is held off with a stall, and the stored entries stay as they were. A pop from an empty queue is also stalled, and no entry is produced. Popped words and stamps come out of registers one cycle after the pop is accepted. The cycle counter is part of the block, and its current value is also driven out as a port.

Top module: `evt_stamp_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `pop_valid` is 0 and `cycle_count` is 0.
- R2: `cycle_count` is TS_W bits wide (default 32). It rises by exactly one on every clock and wraps from all ones to zero with no other effect.
- R3: The stamp stored with an entry equals the `cycle_count` value seen during the cycle in which that push was accepted.
- R4: Entries leave the queue in the order they were accepted, each with its own word and stamp.
- R5: `full` is 1 exactly when DEPTH entries are held. A push request while full raises `push_stall`, is not accepted and changes no stored entry.
- R6: `empty` is 1 exactly when no entry is held. A pop request while empty raises `pop_stall`, produces no `pop_valid` pulse and leaves the queue empty.
- R7: When the queue is neither empty nor full, a push and a pop in the same cycle are both accepted and `empty`/`full` do not change.
- R8: `pop_valid` is 1 in the cycle after an accepted pop and 0 otherwise. `pop_data` and `pop_stamp` then show the popped entry.
- R9: When the queue is full, a push and a pop in the same cycle accept only the pop. `push_stall` is 1 and `full` drops to 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Producer asks to store `push_data` |
| push_data | input | DATA_W | Event word to store |
| push_stall | output | 1 | Push requested while full; not accepted |
| full | output | 1 | Queue holds DEPTH entries |
| pop_req | input | 1 | Consumer asks for the oldest entry |
| pop_stall | output | 1 | Pop requested while empty; not accepted |
| empty | output | 1 | Queue holds no entry |
| pop_valid | output | 1 | Pop result registered this cycle |
| pop_data | output | DATA_W | Event word of the popped entry |
| pop_stamp | output | TS_W | Cycle stamp of the popped entry |
| cycle_count | output | TS_W | Current free-running cycle count |

## Verification
The hardest case to reach from the ports is a push and a pop arriving together on a full queue. The queue must first be filled, and the conflicting request must then be presented in that same cycle. Afterwards the queue is drained to show that the rejected word never entered. Counter wrap is reached by building the bench with a narrow stamp width, so the all-ones-to-zero step comes within about a thousand cycles. Stamps are checked after idle gaps between pushes, so each stored stamp differs from the pop cycle's count.

// File: rtl/evt_fifo_pkg.sv
package evt_fifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] count
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + TS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    // R2: counter advances by one each cycle, wrapping silently
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> s_q.cnt == $past(s_q.cnt) + TS_W'(1));
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
    import evt_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_req,
    input  logic                       pop_req,
    output logic                       push_ok,
    output logic                       pop_ok,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   rd_addr
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    fifo_op_e    op;

    assign full    = (s_q.cnt == FULL_CNT);
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push_req & ~full;
    assign pop_ok  = pop_req & ~empty;
    assign op      = fifo_op_e'({push_ok, pop_ok});

    always_comb begin
        s_d = s_q;
        unique case (op)
            OP_PUSH: begin
                s_d.wr  = s_q.wr + AW'(1);
                s_d.cnt = s_q.cnt + (AW+1)'(1);
            end
            OP_POP: begin
                s_d.rd  = s_q.rd + AW'(1);
                s_d.cnt = s_q.cnt - (AW+1)'(1);
            end
            OP_BOTH: begin
                s_d.wr = s_q.wr + AW'(1);
                s_d.rd = s_q.rd + AW'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_addr = s_q.wr;
    assign rd_addr = s_q.rd;

    // R5: occupancy never exceeds the depth
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);

    // R5: a full queue stays full unless something is popped
    assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_req) |=> full);

    // R6: an empty queue stays empty unless something is pushed
    assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_req) |=> empty);

    // R7: concurrent accepted push and pop keep the occupancy steady
    assert_count_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(s_q.cnt));
endmodule

// File: rtl/entry_store.sv
module entry_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int TS_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  wa,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [TS_W-1:0]           wstamp,
    input  logic                      re,
    input  logic [$clog2(DEPTH)-1:0]  ra,
    output logic                      rvalid,
    output logic [DATA_W-1:0]         rdata,
    output logic [TS_W-1:0]           rstamp
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   stamp;
    } entry_t;

    typedef struct packed {
        entry_t rd;
        logic   vld;
    } out_state_t;

    entry_t     mem_d [DEPTH];
    entry_t     mem_q [DEPTH];
    out_state_t o_d, o_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wa].data  = wdata;
            mem_d[wa].stamp = wstamp;
        end
        o_d     = o_q;
        o_d.vld = re;
        if (re) o_d.rd = mem_q[ra];
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rvalid = o_q.vld;
    assign rdata  = o_q.rd.data;
    assign rstamp = o_q.rd.stamp;

    // R8: output entry only changes on the cycle after a read
    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!re && $past(rst_n)) |=> $stable(o_q.rd));
endmodule

// File: rtl/evt_stamp_fifo.sv
module evt_stamp_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int TS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_stall,
    output logic              full,
    input  logic              pop_req,
    output logic              pop_stall,
    output logic              empty,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic [TS_W-1:0]   pop_stamp,
    output logic [TS_W-1:0]   cycle_count
);
    localparam int AW = $clog2(DEPTH);

    logic          push_ok, pop_ok;
    logic [AW-1:0] wr_addr, rd_addr;

    stamp_counter #(.TS_W(TS_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cycle_count)
    );

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .full     (full),
        .empty    (empty),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr)
    );

    entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TS_W(TS_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (push_ok),
        .wa     (wr_addr),
        .wdata  (push_data),
        .wstamp (cycle_count),
        .re     (pop_ok),
        .ra     (rd_addr),
        .rvalid (pop_valid),
        .rdata  (pop_data),
        .rstamp (pop_stamp)
    );

    assign push_stall = push_req & full;
    assign pop_stall  = pop_req & empty;

    // R6: a stalled pop yields no result
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> !pop_valid);

    // R8: a result appears one cycle after a pop request on a non-empty queue
    assert_valid_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty) |=> pop_valid);

    // R9: on a full queue a pop still goes through, and the queue is no longer full
    assert_full_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop_req) |=> !full);
endmodule

// File: tb/test_evt_stamp_fifo.sv
module test_evt_stamp_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int TS_W   = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              push_req;
    logic [DATA_W-1:0] push_data;
    logic              push_stall, full;
    logic              pop_req;
    logic              pop_stall, empty, pop_valid;
    logic [DATA_W-1:0] pop_data;
    logic [TS_W-1:0]   pop_stamp, cycle_count;

    int checks = 0;
    int errors = 0;

    logic [DATA_W+TS_W-1:0] model[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_stamp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TS_W(TS_W)) i_evt_stamp_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(push_data), .push_stall(push_stall), .full(full),
        .pop_req(pop_req), .pop_stall(pop_stall), .empty(empty), .pop_valid(pop_valid),
        .pop_data(pop_data), .pop_stamp(pop_stamp), .cycle_count(cycle_count)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus; inputs are applied 1 time unit after a rising edge.
    task automatic cyc(input string tag, input logic do_push, input logic [DATA_W-1:0] d, input logic do_pop);
        logic                   acc_push, acc_pop;
        logic [DATA_W+TS_W-1:0] exp_ent;
        logic [TS_W-1:0]        stamp_now;
        push_req  = do_push;
        push_data = d;
        pop_req   = do_pop;
        #1;
        acc_push  = do_push && (model.size() < DEPTH);
        acc_pop   = do_pop && (model.size() > 0);
        stamp_now = cycle_count;
        chk(tag, "push_stall", push_stall, do_push && (model.size() == DEPTH));
        chk(tag, "pop_stall", pop_stall, do_pop && (model.size() == 0));
        exp_ent = acc_pop ? model[0] : '0;
        @(posedge clk); #1;
        if (acc_pop) void'(model.pop_front());
        if (acc_push) model.push_back({d, stamp_now});
        push_req = 1'b0;
        pop_req  = 1'b0;
        chk(tag, "pop_valid", pop_valid, acc_pop);
        if (acc_pop) begin
            chk(tag, "pop_data", pop_data, exp_ent[DATA_W+TS_W-1:TS_W]);
            chk(tag, "pop_stamp", pop_stamp, exp_ent[TS_W-1:0]);
        end
        chk(tag, "full", full, model.size() == DEPTH);
        chk(tag, "empty", empty, model.size() == 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drain(input string tag);
        while (model.size() > 0) cyc(tag, 1'b0, '0, 1'b1);
        chk(tag, "empty after drain", empty, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1", "empty", empty, 1'b1);
        chk("R1", "full", full, 1'b0);
        chk("R1", "pop_valid", pop_valid, 1'b0);
        chk("R1", "cycle_count", cycle_count, 0);
    endtask

    task automatic t_counter;
        logic [TS_W-1:0] prev;
        prev = cycle_count;
        idle(1);
        chk("R2", "count step", cycle_count, prev + TS_W'(1));
        while (cycle_count != {TS_W{1'b1}}) idle(1);
        idle(1);
        chk("R2", "count wrap", cycle_count, 0);
        idle(1);
        chk("R2", "count after wrap", cycle_count, 1);
    endtask

    task automatic t_order_stamp;
        cyc("R3", 1'b1, 16'hA001, 1'b0);
        idle(3);
        cyc("R3", 1'b1, 16'hA002, 1'b0);
        idle(5);
        cyc("R3", 1'b1, 16'hA003, 1'b0);
        idle(2);
        cyc("R4", 1'b0, '0, 1'b1);
        cyc("R8", 1'b0, '0, 1'b0);
        chk("R8", "pop_data held", pop_data, 16'hA001);
        cyc("R4", 1'b0, '0, 1'b1);
        cyc("R4", 1'b0, '0, 1'b1);
    endtask

    task automatic t_fill;
        for (int i = 0; i < DEPTH; i++) cyc("R5", 1'b1, DATA_W'(16'hB000 + i), 1'b0);
        chk("R5", "full after fill", full, 1'b1);
        cyc("R5", 1'b1, 16'hDEAD, 1'b0);
        cyc("R5", 1'b1, 16'hBEEF, 1'b0);
        drain("R5");
    endtask

    task automatic t_empty;
        cyc("R6", 1'b0, '0, 1'b1);
        cyc("R6", 1'b0, '0, 1'b1);
        chk("R6", "still empty", empty, 1'b1);
    endtask

    task automatic t_both;
        cyc("R7", 1'b1, 16'hC001, 1'b0);
        idle(1);
        cyc("R7", 1'b1, 16'hC002, 1'b0);
        for (int i = 0; i < 4; i++) cyc("R7", 1'b1, DATA_W'(16'hC100 + i), 1'b1);
        chk("R7", "occupancy two", model.size(), 2);
        drain("R7");
    endtask

    task automatic t_full_both;
        for (int i = 0; i < DEPTH; i++) cyc("R9", 1'b1, DATA_W'(16'hD000 + i), 1'b0);
        cyc("R9", 1'b1, 16'hFFFF, 1'b1);
        chk("R9", "not full", full, 1'b0);
        drain("R9");
    endtask

    initial begin
        push_req  = 1'b0;
        pop_req   = 1'b0;
        push_data = '0;
        rst_n     = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        t_reset();
        t_counter();
        t_order_stamp();
        t_fill();
        t_empty();
        t_both();
        t_full_both();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule